// File: doc/BRIEF.md
# SPI Interrupt Status and FIFO Watermark Unit

This block keeps the interrupt-status word of a SPI controller and drives its single level-sensitive interrupt line. It watches the live fill counts of the transmit and receive FIFOs and turns them into watermark flags: not-empty, full, quarter, half and three-quarter thresholds on each side. Each threshold is defined by its own inequality on either used or free entries. Alongside these level flags it holds sticky event flags that are raised by one-cycle pulses from the transfer engine: overflow and underflow on each FIFO, transfer done, and a chip-select event.

Software clears sticky flags by writing ones to the status word. Level flags cannot be cleared that way, because they are rebuilt from the counts every cycle. A reset of either FIFO forces its level flags to the empty pattern and drops that FIFO's error flags. Bit 31 mirrors a configuration-busy input and is never touched by a clear write. The interrupt output is the OR of the status word masked by a software enable word.

The FIFOs and the transfer engine are outside the block. They are represented only by count inputs and event pulses.

Top module: `spi_irq_status_unit`

## Requirements
- R1: After reset the status word reads 0x00001B00 (bits 8, 9, 11 and 12 set), the enable word reads 0 and irq is low.
- R2: One cycle after the RX count is presented, status bits reflect it. Bit 0 is set when used is not 0. Bit 2 is set when used equals DEPTH. Bit 3 is set when used is at least DEPTH/4. Bit 1 is set when used is at least DEPTH/2. Bit 4 is set when free (DEPTH minus used) is at most DEPTH/4.
- R3: One cycle after the TX count is presented, status bits reflect it. Bit 8 is set when used is 0. Bit 10 is set when used equals DEPTH. Bit 11 is set when free is at least DEPTH/4. Bit 9 is set when free is at least DEPTH/2. Bit 12 is set when used is at most DEPTH/4.
- R4: A one-cycle event pulse sets its sticky bit on the next cycle, and the bit stays set afterwards. The mapping is: RX overflow to bit 5, RX underflow to bit 6, TX overflow to bit 13, TX underflow to bit 14, transfer done to bit 16, chip-select event to bit 17.
- R5: A status write clears each sticky bit whose data bit is 1 and leaves every sticky bit whose data bit is 0 unchanged.
- R6: A status write has no effect on the level bits (0 to 4 and 8 to 12); the next cycle they still reflect the counts.
- R7: Bit 31 shows the cfg_busy input one cycle late and is never cleared by a status write.
- R8: A TX FIFO reset pulse sets bits 8, 9, 11 and 12 and clears bits 13 and 14 on the next cycle, whatever the TX count was in that cycle.
- R9: An RX FIFO reset pulse makes bits 0 to 6 read 0 on the next cycle, whatever the RX count was.
- R10: When an event pulse arrives in the same cycle as a clear (a status write or a FIFO reset) of the same bit, the bit ends up set.
- R11: An enable write stores its data ANDed with 0x00037F7F, and the stored value reads back on ien.
- R12: irq is high exactly when status AND ien is non-zero. Because the enable word cannot hold bit 31, cfg_busy alone never raises irq.
- R13: Status bits 7, 15 and 18 to 30 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_used | input | CNT_W | Entries held in the RX FIFO (0..DEPTH) |
| tx_used | input | CNT_W | Entries held in the TX FIFO (0..DEPTH) |
| sts_wr_en | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wr_data | input | 32 | Status write data |
| ien_wr_en | input | 1 | Enable word write strobe |
| ien_wr_data | input | 32 | Enable word write data |
| tx_fifo_rst | input | 1 | TX FIFO reset pulse |
| rx_fifo_rst | input | 1 | RX FIFO reset pulse |
| evt_rx_ovf | input | 1 | RX overflow event pulse |
| evt_rx_udf | input | 1 | RX underflow event pulse |
| evt_tx_ovf | input | 1 | TX overflow event pulse |
| evt_tx_udf | input | 1 | TX underflow event pulse |
| evt_xfer_done | input | 1 | Transfer done event pulse |
| evt_cs | input | 1 | Chip-select event pulse |
| cfg_busy | input | 1 | Configuration busy level, shown in bit 31 |
| status | output | 32 | Interrupt status word |
| ien | output | 32 | Interrupt enable word |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach from the ports is a clear and a set landing on the same sticky bit in one cycle, together with a FIFO reset while the count still shows a full FIFO. The bench builds both cases directly. It raises the event pulse in the same cycle as the write strobe or the reset pulse, and it holds the counts at DEPTH across the reset. Each watermark flag is walked across its boundary by stepping the counts through the values one below, at, and one above each threshold.

// File: rtl/spi_irq_pkg.sv
`timescale 1ns/1ps
package spi_irq_pkg;
  // Bit positions are decoded by software and the enable word
  localparam int unsigned B_RX_RDY    = 0;
  localparam int unsigned B_RX_HALF   = 1;
  localparam int unsigned B_RX_FULL   = 2;
  localparam int unsigned B_RX_QTR    = 3;
  localparam int unsigned B_RX_3QTR   = 4;
  localparam int unsigned B_RX_OVF    = 5;
  localparam int unsigned B_RX_UDF    = 6;
  localparam int unsigned B_TX_EMPTY  = 8;
  localparam int unsigned B_TX_HALF   = 9;
  localparam int unsigned B_TX_FULL   = 10;
  localparam int unsigned B_TX_QTR    = 11;
  localparam int unsigned B_TX_3QTR   = 12;
  localparam int unsigned B_TX_OVF    = 13;
  localparam int unsigned B_TX_UDF    = 14;
  localparam int unsigned B_XFER_DONE = 16;
  localparam int unsigned B_CS_EVT    = 17;
  localparam int unsigned B_CFG_BUSY  = 31;

  localparam int unsigned STS_W = 32;

  localparam logic [STS_W-1:0] LEVEL_MASK  = 32'h0000_1F1F;
  localparam logic [STS_W-1:0] STICKY_MASK = 32'h0003_6060;
  localparam logic [STS_W-1:0] CLR_MASK    = 32'h0003_7F7F;
  localparam logic [STS_W-1:0] IEN_MASK    = 32'h0003_7F7F;
  localparam logic [STS_W-1:0] STS_RESET   = 32'h0000_1B00;
  localparam logic [STS_W-1:0] TX_RST_SET  = 32'h0000_1B00;
  localparam logic [STS_W-1:0] TX_RST_CLR  = 32'h0000_6000;
  localparam logic [STS_W-1:0] RX_RST_CLR  = 32'h0000_007F;

  typedef struct packed {
    logic rx_ovf;
    logic rx_udf;
    logic tx_ovf;
    logic tx_udf;
    logic xfer_done;
    logic cs;
  } evt_t;
endpackage

// File: rtl/spi_irq_level_calc.sv
`timescale 1ns/1ps
module spi_irq_level_calc
  import spi_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [CNT_W-1:0] rx_used,
  input  logic [CNT_W-1:0] tx_used,
  output logic [STS_W-1:0] lvl_vec
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] QTR_C   = CNT_W'(FIFO_DEPTH / 4);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(FIFO_DEPTH / 2);

  logic [CNT_W-1:0] rx_free;
  logic [CNT_W-1:0] tx_free;

  always_comb begin
    rx_free = DEPTH_C - rx_used;
    tx_free = DEPTH_C - tx_used;
    lvl_vec = '0;
    // receive side: mostly "used" thresholds, three-quarter uses free
    lvl_vec[B_RX_RDY]   = (rx_used != '0);
    lvl_vec[B_RX_FULL]  = (rx_used == DEPTH_C);
    lvl_vec[B_RX_QTR]   = (rx_used >= QTR_C);
    lvl_vec[B_RX_HALF]  = (rx_used >= HALF_C);
    lvl_vec[B_RX_3QTR]  = (rx_free <= QTR_C);
    // transmit side: mostly "free" thresholds, three-quarter uses used
    lvl_vec[B_TX_EMPTY] = (tx_used == '0);
    lvl_vec[B_TX_FULL]  = (tx_used == DEPTH_C);
    lvl_vec[B_TX_QTR]   = (tx_free >= QTR_C);
    lvl_vec[B_TX_HALF]  = (tx_free >= HALF_C);
    lvl_vec[B_TX_3QTR]  = (tx_used <= QTR_C);
  end
endmodule

// File: rtl/spi_irq_sticky.sv
`timescale 1ns/1ps
module spi_irq_sticky
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set_vec,
  input  logic [STS_W-1:0] clr_vec,
  output logic [STS_W-1:0] sticky_vec
);
  logic unused_nonsticky;
  assign unused_nonsticky = ^((set_vec | clr_vec) & ~STICKY_MASK);

  for (genvar g = 0; g < STS_W; g++) begin : g_bit
    if (STICKY_MASK[g]) begin : g_flop
      logic bit_q;
      logic bit_n;
      // set beats clear so an event is never lost
      always_comb bit_n = set_vec[g] | (bit_q & ~clr_vec[g]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_n;
      end
      assign sticky_vec[g] = bit_q;
    end else begin : g_zero
      assign sticky_vec[g] = 1'b0;
    end
  end
endmodule

// File: rtl/spi_irq_combine.sv
`timescale 1ns/1ps
module spi_irq_combine
  import spi_irq_pkg::*;
(
  input  logic [STS_W-1:0] status,
  input  logic [STS_W-1:0] ien,
  output logic             irq
);
  always_comb irq = |(status & ien);
endmodule

// File: rtl/spi_irq_status_unit.sv
`timescale 1ns/1ps
module spi_irq_status_unit
  import spi_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_used,
  input  logic [CNT_W-1:0] tx_used,
  input  logic             sts_wr_en,
  input  logic [31:0]      sts_wr_data,
  input  logic             ien_wr_en,
  input  logic [31:0]      ien_wr_data,
  input  logic             tx_fifo_rst,
  input  logic             rx_fifo_rst,
  input  logic             evt_rx_ovf,
  input  logic             evt_rx_udf,
  input  logic             evt_tx_ovf,
  input  logic             evt_tx_udf,
  input  logic             evt_xfer_done,
  input  logic             evt_cs,
  input  logic             cfg_busy,
  output logic [31:0]      status,
  output logic [31:0]      ien,
  output logic             irq
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta_q;
  logic rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  // level flags
  logic [STS_W-1:0] lvl_vec;
  logic [STS_W-1:0] lvl_n;
  logic [STS_W-1:0] lvl_q;

  spi_irq_level_calc #(.FIFO_DEPTH(FIFO_DEPTH)) u_level (
    .rx_used (rx_used),
    .tx_used (tx_used),
    .lvl_vec (lvl_vec)
  );

  always_comb begin
    lvl_n = lvl_vec & LEVEL_MASK;
    if (tx_fifo_rst) lvl_n = lvl_n | TX_RST_SET;
    if (rx_fifo_rst) lvl_n = lvl_n & ~RX_RST_CLR;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) lvl_q <= STS_RESET & LEVEL_MASK;
    else             lvl_q <= lvl_n;
  end

  // sticky events
  evt_t             evt;
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] clr_vec;
  logic [STS_W-1:0] sticky_vec;
  logic [STS_W-1:0] wr_clr;

  always_comb begin
    evt = '{rx_ovf: evt_rx_ovf, rx_udf: evt_rx_udf, tx_ovf: evt_tx_ovf,
            tx_udf: evt_tx_udf, xfer_done: evt_xfer_done, cs: evt_cs};
    set_vec = '0;
    set_vec[B_RX_OVF]    = evt.rx_ovf;
    set_vec[B_RX_UDF]    = evt.rx_udf;
    set_vec[B_TX_OVF]    = evt.tx_ovf;
    set_vec[B_TX_UDF]    = evt.tx_udf;
    set_vec[B_XFER_DONE] = evt.xfer_done;
    set_vec[B_CS_EVT]    = evt.cs;
    wr_clr  = sts_wr_en ? (sts_wr_data & CLR_MASK) : '0;
    clr_vec = wr_clr
            | (tx_fifo_rst ? TX_RST_CLR : '0)
            | (rx_fifo_rst ? RX_RST_CLR : '0);
  end

  spi_irq_sticky u_sticky (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .sticky_vec (sticky_vec)
  );

  // busy mirror
  logic busy_q;
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) busy_q <= 1'b0;
    else             busy_q <= cfg_busy;
  end

  // enable word with explicit clock enable
  logic [STS_W-1:0] ien_q;
  logic [STS_W-1:0] ien_n;
  always_comb ien_n = ien_wr_en ? (ien_wr_data & IEN_MASK) : ien_q;
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) ien_q <= '0;
    else             ien_q <= ien_n;
  end

  logic [STS_W-1:0] status_w;
  always_comb begin
    status_w = lvl_q | sticky_vec;
    status_w[B_CFG_BUSY] = busy_q;
  end

  spi_irq_combine u_combine (
    .status (status_w),
    .ien    (ien_q),
    .irq    (irq)
  );

  assign status = status_w;
  assign ien    = ien_q;
endmodule

// File: rtl/spi_irq_status_unit_chk.sv
`timescale 1ns/1ps
module spi_irq_status_unit_chk #(
  parameter int unsigned FIFO_DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] rx_used,
  input logic [CNT_W-1:0] tx_used,
  input logic             sts_wr_en,
  input logic             wr_done_bit,
  input logic             tx_fifo_rst,
  input logic             rx_fifo_rst,
  input logic             evt_rx_ovf,
  input logic             evt_rx_udf,
  input logic             evt_xfer_done,
  input logic             cfg_busy,
  input logic [31:0]      status,
  input logic [31:0]      ien,
  input logic             irq
);
  a_r2_rx_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rx_fifo_rst)) |-> (status[0] == ($past(rx_used) != '0)));

  a_r3_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tx_fifo_rst)) |-> (status[8] == ($past(tx_used) == '0)));

  a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(status[16]) && !($past(sts_wr_en) && $past(wr_done_bit)))
      |-> status[16]);

  a_r7_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status[31] == $past(cfg_busy)));

  a_r8_tx_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tx_fifo_rst)) |-> (status[8] && status[9] && status[11] && status[12]));

  a_r9_rx_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rx_fifo_rst) && !$past(evt_rx_ovf) && !$past(evt_rx_udf))
      |-> (status[6:0] == 7'd0));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(evt_xfer_done)) |-> status[16]);

  a_r12_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((status & ien) != 32'd0));

  a_r13_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 32'h7FFC_8080) == 32'd0);
endmodule

bind spi_irq_status_unit spi_irq_status_unit_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_sync),
  .rx_used       (rx_used),
  .tx_used       (tx_used),
  .sts_wr_en     (sts_wr_en),
  .wr_done_bit   (sts_wr_data[16]),
  .tx_fifo_rst   (tx_fifo_rst),
  .rx_fifo_rst   (rx_fifo_rst),
  .evt_rx_ovf    (evt_rx_ovf),
  .evt_rx_udf    (evt_rx_udf),
  .evt_xfer_done (evt_xfer_done),
  .cfg_busy      (cfg_busy),
  .status        (status),
  .ien           (ien),
  .irq           (irq)
);

// File: tb/spi_irq_status_unit_bench.sv
`timescale 1ns/1ps
module spi_irq_status_unit_bench;
  localparam int D = 64;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] rx_used, tx_used;
  logic          sts_wr_en, ien_wr_en, tx_fifo_rst, rx_fifo_rst;
  logic [31:0]   sts_wr_data, ien_wr_data;
  logic          evt_rx_ovf, evt_rx_udf, evt_tx_ovf, evt_tx_udf, evt_xfer_done, evt_cs;
  logic          cfg_busy;
  logic [31:0]   status, ien;
  logic          irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_irq_status_unit #(.FIFO_DEPTH(D)) u_spi_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .rx_used(rx_used), .tx_used(tx_used),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
    .ien_wr_en(ien_wr_en), .ien_wr_data(ien_wr_data),
    .tx_fifo_rst(tx_fifo_rst), .rx_fifo_rst(rx_fifo_rst),
    .evt_rx_ovf(evt_rx_ovf), .evt_rx_udf(evt_rx_udf),
    .evt_tx_ovf(evt_tx_ovf), .evt_tx_udf(evt_tx_udf),
    .evt_xfer_done(evt_xfer_done), .evt_cs(evt_cs), .cfg_busy(cfg_busy),
    .status(status), .ien(ien), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  // inputs change just after a falling edge; one rising edge follows
  task automatic tick();
    @(negedge clk);
    sts_wr_en = 0; ien_wr_en = 0; tx_fifo_rst = 0; rx_fifo_rst = 0;
    evt_rx_ovf = 0; evt_rx_udf = 0; evt_tx_ovf = 0; evt_tx_udf = 0;
    evt_xfer_done = 0; evt_cs = 0;
  endtask

  function automatic logic [31:0] exp_rx(int u);
    logic [31:0] v = '0;
    v[0] = (u != 0);
    v[1] = (u >= D/2);
    v[2] = (u == D);
    v[3] = (u >= D/4);
    v[4] = ((D - u) <= D/4);
    return v;
  endfunction

  function automatic logic [31:0] exp_tx(int u);
    logic [31:0] v = '0;
    v[8]  = (u == 0);
    v[9]  = ((D - u) >= D/2);
    v[10] = (u == D);
    v[11] = ((D - u) >= D/4);
    v[12] = (u <= D/4);
    return v;
  endfunction

  task automatic t_reset();
    chk("R1 status after reset", status, 32'h0000_1B00);
    chk("R1 ien after reset", ien, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rx_levels();
    int pts[10] = '{0, 1, 15, 16, 31, 32, 47, 48, 63, 64};
    foreach (pts[i]) begin
      rx_used = CW'(pts[i]);
      tick();
      chk($sformatf("R2 rx flags used=%0d", pts[i]), status & 32'h1F, exp_rx(pts[i]));
    end
    rx_used = 0;
    tick();
  endtask

  task automatic t_tx_levels();
    int pts[11] = '{0, 1, 16, 17, 31, 32, 33, 48, 49, 63, 64};
    foreach (pts[i]) begin
      tx_used = CW'(pts[i]);
      tick();
      chk($sformatf("R3 tx flags used=%0d", pts[i]), status & 32'h1F00, exp_tx(pts[i]));
    end
    tx_used = 0;
    tick();
  endtask

  task automatic t_events_w1c();
    evt_rx_ovf = 1; evt_rx_udf = 1; evt_tx_ovf = 1; evt_tx_udf = 1;
    evt_xfer_done = 1; evt_cs = 1;
    tick();
    chk("R4 sticky set", status & 32'h0003_6060, 32'h0003_6060);
    tick(); tick();
    chk("R4 sticky held", status & 32'h0003_6060, 32'h0003_6060);
    sts_wr_en = 1; sts_wr_data = 32'h0001_0000;
    tick();
    chk("R5 only bit16 cleared", status & 32'h0003_6060, 32'h0002_6060);
    sts_wr_en = 1; sts_wr_data = 32'h0000_2020;
    tick();
    chk("R5 bits 5,13 cleared", status & 32'h0003_6060, 32'h0002_4040);
    sts_wr_en = 1; sts_wr_data = 32'hFFFF_FFFF;
    tick();
    chk("R5 all sticky cleared", status & 32'h0003_6060, 32'h0);
  endtask

  task automatic t_level_w1c();
    rx_used = CW'(D);
    tick();
    sts_wr_en = 1; sts_wr_data = 32'hFFFF_FFFF;
    tick();
    chk("R6 level bits survive write", status & 32'h1F1F, exp_rx(D) | exp_tx(0));
    rx_used = 0;
    tick();
  endtask

  task automatic t_busy();
    cfg_busy = 1;
    tick();
    chk("R7 bit31 follows busy", status & 32'h8000_0000, 32'h8000_0000);
    sts_wr_en = 1; sts_wr_data = 32'h8000_0000;
    tick();
    chk("R7 bit31 not cleared by write", status & 32'h8000_0000, 32'h8000_0000);
    cfg_busy = 0;
    tick();
    chk("R7 bit31 drops with busy", status & 32'h8000_0000, 32'h0);
  endtask

  task automatic t_fifo_resets();
    tx_used = CW'(D); evt_tx_ovf = 1; evt_tx_udf = 1;
    tick();
    chk("R8 pre-reset tx state", status & 32'h7F00, 32'h6400);
    tx_fifo_rst = 1;
    tick();
    chk("R8 tx reset flags", status & 32'h7B00, 32'h1B00);
    tx_used = 0;
    tick();
    rx_used = CW'(D); evt_rx_ovf = 1; evt_rx_udf = 1;
    tick();
    chk("R9 pre-reset rx state", status & 32'h7F, 32'h7F);
    rx_fifo_rst = 1;
    tick();
    chk("R9 rx reset flags", status & 32'h7F, 32'h0);
    rx_used = 0;
    tick();
  endtask

  task automatic t_priority();
    evt_xfer_done = 1; sts_wr_en = 1; sts_wr_data = 32'h0001_0000;
    tick();
    chk("R10 event beats write clear", status & 32'h0001_0000, 32'h0001_0000);
    evt_tx_udf = 1; tx_fifo_rst = 1;
    tick();
    chk("R10 event beats tx reset", status & 32'h0000_4000, 32'h0000_4000);
    sts_wr_en = 1; sts_wr_data = 32'hFFFF_FFFF;
    tick();
    chk("R13 unused bits zero", status & 32'h7FFC_8080, 32'h0);
  endtask

  task automatic t_ien_irq();
    ien_wr_en = 1; ien_wr_data = 32'hFFFF_FFFF;
    tick();
    chk("R11 ien masked", ien, 32'h0003_7F7F);
    ien_wr_en = 1; ien_wr_data = 32'h0;
    tick();
    chk("R12 irq low with ien=0", {31'b0, irq}, 32'h0);
    ien_wr_en = 1; ien_wr_data = 32'h0000_0100;
    tick();
    chk("R12 irq high on tx empty", {31'b0, irq}, 32'h1);
    ien_wr_en = 1; ien_wr_data = 32'h0000_0001;
    tick();
    chk("R12 irq low on rx ready while empty", {31'b0, irq}, 32'h0);
    tx_used = 7'd49; cfg_busy = 1; ien_wr_en = 1; ien_wr_data = 32'hFFFF_FFFF;
    tick();
    chk("R12 busy-only status", status, 32'h8000_0000);
    chk("R12 busy alone no irq", {31'b0, irq}, 32'h0);
    evt_cs = 1;
    tick();
    chk("R12 irq on cs event", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    rst_n = 0; rx_used = 0; tx_used = 0; cfg_busy = 0;
    sts_wr_en = 0; sts_wr_data = 0; ien_wr_en = 0; ien_wr_data = 0;
    tx_fifo_rst = 0; rx_fifo_rst = 0;
    evt_rx_ovf = 0; evt_rx_udf = 0; evt_tx_ovf = 0; evt_tx_udf = 0;
    evt_xfer_done = 0; evt_cs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rx_levels();
    t_tx_levels();
    t_events_w1c();
    t_level_w1c();
    t_busy();
    t_fifo_resets();
    t_priority();
    t_ien_irq();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule